// File: doc/BRIEF.md
# Parity Link In-Service Monitor

This block watches a parallel receive bus carrying one or more 16-bit words per clock. For every segment of traffic that a control word closes, it computes a 4-bit diagonal interleaved parity and compares it against the check nibble carried in that control word. A control word may sit in any lane, and several may arrive in one clock. A lane's result depends on every earlier lane of the same clock and on the traffic of earlier clocks.

Each clock reduces to two facts: at least one check passed, and at least one check failed. These facts produce a one-cycle error pulse and drive an in-service/out-of-service state machine. The state machine has a bad counter that leads out of service and a good counter that leads back in. The thresholds are captured while reset is held. Data handling elsewhere on the chip is unaffected: the flag only reports link quality.

Top module: `dip_link_monitor`

## Requirements
- R1: The running 16-bit accumulator is rotated left by one bit per word and XORed with the word. A control word takes part with its bits [3:0] forced to 1111. The result is folded into 4 bits (bit i is the XOR of all accumulator bits whose index mod 4 equals i), and that value must equal bits [3:0] of the control word, or the check fails. After each control word the accumulator restarts at zero.
- R2: `parErr` is high for exactly the clock after a clock containing at least one failed check, as one pulse however many checks failed in that clock.
- R3: While and after reset, with no traffic, `outOfService` is 1 and `parErr` is 0. Both counters are cleared.
- R4: In service, a clock with a failed check and no passed check advances the bad counter. When it reaches the bad threshold, the link leaves service. A clock with no check leaves the count unchanged.
- R5: With a bad threshold of 1, one failed check takes the link out of service on the next clock.
- R6: In service, a clock holding both a passed and a failed check clears the bad counter, and the link stays in service.
- R7: Out of service, every clock without a failed check advances the good counter, and a failed check clears it. When the good counter reaches the good threshold, the link returns to service.
- R8: A threshold of 0 acts as 1.
- R9: The thresholds are captured only while `rst` is high. Later changes on `badLevel` or `goodLevel` have no effect.
- R10: Lane 0 is the earliest word of a clock. Several control words in one clock are each checked against the accumulator as it stands at their own lane.
- R11: While `inValid` is low, the accumulator holds and no check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; thresholds are captured while it is high |
| inValid | input | 1 | All lanes carry words this clock |
| inWords | input | LANES*16 | Lane words, lane 0 in bits [15:0] |
| inCtl | input | LANES | Per-lane marker: word is a control word |
| badLevel | input | CNT_W | Bad-counter threshold |
| goodLevel | input | CNT_W | Good-counter threshold |
| parErr | output | 1 | One-clock pulse after a clock with a failed check |
| outOfService | output | 1 | Link out of service |

## Verification
The assertions assume that `inCtl` is meaningful only when `inValid` is high. They also assume the thresholds are set up during reset, so that the captured levels cannot move afterwards. The stimulus drives every lane and marker at the falling edge and builds each control word's check nibble from an independent bench accumulator. Each control word is deliberately corrupted or left correct as the scenario requires. Threshold pins change after reset only in the scenario that tests that they are ignored.

// File: rtl/dipmon_pkg.sv
package dipmon_pkg;
  localparam int DEF_WORD_W = 16;
  localparam int DEF_DIP_W  = 4;

  // per-clock verdict of the datapath, consumed by the service controller
  typedef struct packed {
    logic anyGood;
    logic anyBad;
  } chk_strobe_t;
endpackage

// File: rtl/dip_lane_check.sv
module dip_lane_check
  import dipmon_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int WORD_W = DEF_WORD_W,
  parameter int DIP_W  = DEF_DIP_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [LANES*WORD_W-1:0] inWords,
  input  logic [LANES-1:0]        inCtl,
  output chk_strobe_t             strobe
);
  localparam int FOLDS = WORD_W / DIP_W;

  function automatic logic [WORD_W-1:0] rotOne(input logic [WORD_W-1:0] v);
    return {v[WORD_W-2:0], v[WORD_W-1]};
  endfunction

  function automatic logic [DIP_W-1:0] foldDip(input logic [WORD_W-1:0] v);
    logic [DIP_W-1:0] r;
    r = '0;
    for (int k = 0; k < FOLDS; k++) r = r ^ v[k*DIP_W +: DIP_W];
    return r;
  endfunction

  logic [WORD_W-1:0] accQ;
  logic [WORD_W-1:0] chain [LANES+1];
  logic [LANES-1:0]  laneGood;
  logic [LANES-1:0]  laneBad;

  assign chain[0] = accQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] masked;
    logic [WORD_W-1:0] mixed;
    logic [DIP_W-1:0]  dip;
    assign word   = inWords[g*WORD_W +: WORD_W];
    assign masked = inCtl[g] ? {word[WORD_W-1:DIP_W], {DIP_W{1'b1}}} : word;
    assign mixed  = rotOne(chain[g]) ^ masked;
    assign dip    = foldDip(mixed);
    assign laneGood[g] = inValid & inCtl[g] & (dip == word[DIP_W-1:0]);
    assign laneBad[g]  = inValid & inCtl[g] & (dip != word[DIP_W-1:0]);
    assign chain[g+1]  = inCtl[g] ? '0 : mixed;
  end

  always_ff @(posedge clk) begin
    if (rst)          accQ <= '0;
    else if (inValid) accQ <= chain[LANES];
  end

  assign strobe.anyGood = |laneGood;
  assign strobe.anyBad  = |laneBad;

  AST_CHECK_NEEDS_CTL: assert property (@(posedge clk) disable iff (rst)
    (strobe.anyGood || strobe.anyBad) |-> (inValid && (|inCtl))); // R11

  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    (!inValid) |=> (accQ == $past(accQ))); // R11
endmodule

// File: rtl/svc_fsm.sv
module svc_fsm
  import dipmon_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  chk_strobe_t       strobe,
  input  logic [CNT_W-1:0]  badLevel,
  input  logic [CNT_W-1:0]  goodLevel,
  output logic              parErr,
  output logic              outOfService
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             inSvc;
  logic [CNT_W-1:0] badCnt;
  logic [CNT_W-1:0] goodCnt;
  logic [CNT_W-1:0] badLvlQ;
  logic [CNT_W-1:0] goodLvlQ;
  logic [CNT_W:0]   badNext;
  logic [CNT_W:0]   goodNext;

  assign badNext  = {1'b0, badCnt} + 1'b1;
  assign goodNext = {1'b0, goodCnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      inSvc    <= 1'b0;
      badCnt   <= '0;
      goodCnt  <= '0;
      parErr   <= 1'b0;
      badLvlQ  <= (badLevel  == '0) ? ONE : badLevel;
      goodLvlQ <= (goodLevel == '0) ? ONE : goodLevel;
    end else begin
      parErr <= strobe.anyBad;
      if (inSvc) begin
        if (strobe.anyGood) begin
          badCnt <= '0;
        end else if (strobe.anyBad) begin
          if (badNext >= {1'b0, badLvlQ}) begin
            inSvc   <= 1'b0;
            badCnt  <= '0;
            goodCnt <= '0;
          end else begin
            badCnt <= badNext[CNT_W-1:0];
          end
        end
      end else begin
        if (strobe.anyBad) begin
          goodCnt <= '0;
        end else if (goodNext >= {1'b0, goodLvlQ}) begin
          inSvc   <= 1'b1;
          goodCnt <= '0;
          badCnt  <= '0;
        end else begin
          goodCnt <= goodNext[CNT_W-1:0];
        end
      end
    end
  end

  assign outOfService = ~inSvc;

  AST_STAY_WITHOUT_ERR: assert property (@(posedge clk) disable iff (rst)
    (inSvc && !strobe.anyBad) |=> inSvc); // R4
  AST_BAD_BELOW_LEVEL: assert property (@(posedge clk) disable iff (rst)
    badCnt < badLvlQ); // R4
  AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (rst)
    (inSvc && strobe.anyBad && !strobe.anyGood && badLvlQ == ONE) |=> !inSvc); // R5
  AST_MIXED_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (inSvc && strobe.anyGood) |=> inSvc); // R6
  AST_NO_EARLY_RETURN: assert property (@(posedge clk) disable iff (rst)
    (!inSvc && strobe.anyBad) |=> !inSvc); // R7
  AST_ERR_FOLLOWS_BAD: assert property (@(posedge clk) disable iff (rst)
    strobe.anyBad |=> parErr); // R2
  AST_LEVELS_HELD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(badLvlQ) && $stable(goodLvlQ))); // R9
  AST_LEVELS_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (badLvlQ != '0) && (goodLvlQ != '0)); // R8
endmodule

// File: rtl/dip_link_monitor.sv
module dip_link_monitor
  import dipmon_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int WORD_W = DEF_WORD_W,
  parameter int DIP_W  = DEF_DIP_W,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic [LANES*WORD_W-1:0] inWords,
  input  logic [LANES-1:0]        inCtl,
  input  logic [CNT_W-1:0]        badLevel,
  input  logic [CNT_W-1:0]        goodLevel,
  output logic                    parErr,
  output logic                    outOfService
);
  chk_strobe_t strobe;

  dip_lane_check #(
    .LANES (LANES),
    .WORD_W(WORD_W),
    .DIP_W (DIP_W)
  ) uCheck (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .inWords(inWords),
    .inCtl  (inCtl),
    .strobe (strobe)
  );

  svc_fsm #(
    .CNT_W(CNT_W)
  ) uSvc (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .badLevel    (badLevel),
    .goodLevel   (goodLevel),
    .parErr      (parErr),
    .outOfService(outOfService)
  );
endmodule

// File: tb/sim_dip_link_monitor.sv
module sim_dip_link_monitor;
  localparam int LANES = 2;
  localparam int CNT_W = 8;
  localparam int NROWS = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [LANES*16-1:0] inWords = '0;
  logic [LANES-1:0] inCtl = '0;
  logic [CNT_W-1:0] badLevel = 8'd3;
  logic [CNT_W-1:0] goodLevel = 8'd4;
  logic parErr;
  logic outOfService;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] mAcc;
  bit mInSvc;
  int mBad, mGood, mBadLvl, mGoodLvl;

  always #4 clk = ~clk;

  dip_link_monitor u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inWords(inWords), .inCtl(inCtl),
    .badLevel(badLevel), .goodLevel(goodLevel),
    .parErr(parErr), .outOfService(outOfService)
  );

  // row: [36] valid, [35:34] ctl, [33:32] corrupt, [31:16] lane1, [15:0] lane0
  localparam logic [36:0] ROWS [0:NROWS-1] = '{
    {1'b1, 2'b00, 2'b00, 16'h1234, 16'hABCD},
    {1'b1, 2'b00, 2'b00, 16'h0F0F, 16'h8001},
    {1'b0, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF},
    {1'b1, 2'b01, 2'b00, 16'h5A5A, 16'hC3C0},
    {1'b1, 2'b00, 2'b00, 16'h7777, 16'h0001},
    {1'b1, 2'b10, 2'b10, 16'hE000, 16'h2468},
    {1'b1, 2'b01, 2'b01, 16'h1357, 16'hD000},
    {1'b1, 2'b11, 2'b01, 16'hB000, 16'h9000},
    {1'b1, 2'b10, 2'b10, 16'h4000, 16'h3C3C},
    {1'b1, 2'b11, 2'b11, 16'h6000, 16'h7000},
    {1'b1, 2'b00, 2'b00, 16'h0101, 16'h1010},
    {1'b0, 2'b01, 2'b01, 16'h0000, 16'h0000},
    {1'b1, 2'b01, 2'b01, 16'hAAAA, 16'h5550},
    {1'b1, 2'b00, 2'b00, 16'h1111, 16'h2222},
    {1'b1, 2'b10, 2'b10, 16'h8000, 16'h3333},
    {1'b1, 2'b00, 2'b00, 16'h4444, 16'h5555},
    {1'b1, 2'b11, 2'b00, 16'h6660, 16'h7770},
    {1'b1, 2'b00, 2'b00, 16'h8888, 16'h9999},
    {1'b1, 2'b01, 2'b00, 16'hCAFE, 16'hBEE0},
    {1'b1, 2'b01, 2'b00, 16'h0000, 16'hF00D}
  };

  function automatic logic [15:0] spin(input logic [15:0] v);
    return {v[14:0], v[15]};
  endfunction

  function automatic logic [3:0] squeeze(input logic [15:0] v);
    logic [3:0] r = 4'h0;
    for (int b = 0; b < 16; b++) r[b % 4] = r[b % 4] ^ v[b];
    return r;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic doReset(input int bl, input int gl);
    rst = 1'b1;
    inValid = 1'b0;
    inCtl = '0;
    badLevel = CNT_W'(bl);
    goodLevel = CNT_W'(gl);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mAcc = '0; mInSvc = 1'b0; mBad = 0; mGood = 0;
    mBadLvl = (bl == 0) ? 1 : bl;
    mGoodLvl = (gl == 0) ? 1 : gl;
    check("R3 reset outOfService", outOfService, 1'b1);
    check("R3 reset parErr", parErr, 1'b0);
  endtask

  // drive one clock at a falling edge, then check outputs at the next one
  task automatic applyRow(input logic v, input logic [1:0] c, input logic [1:0] bd,
                          input logic [15:0] d1, input logic [15:0] d0, input string tag);
    logic [15:0] w [2];
    logic [15:0] t;
    bit sawGood = 0, sawBad = 0;
    w[0] = d0; w[1] = d1;
    for (int l = 0; l < 2; l++) begin
      if (c[l]) begin
        t = spin(mAcc) ^ {w[l][15:4], 4'hF};
        w[l][3:0] = squeeze(t) ^ (bd[l] ? 4'h1 : 4'h0);
        if (v) begin
          if (bd[l]) sawBad = 1; else sawGood = 1;
          mAcc = '0;
        end
      end else if (v) begin
        mAcc = spin(mAcc) ^ w[l];
      end
    end
    inValid = v;
    inCtl = c;
    inWords = {w[1], w[0]};
    @(negedge clk);
    if (mInSvc) begin
      if (sawGood) mBad = 0;
      else if (sawBad) begin
        if (mBad + 1 >= mBadLvl) begin mInSvc = 0; mBad = 0; mGood = 0; end
        else mBad++;
      end
    end else begin
      if (sawBad) mGood = 0;
      else if (mGood + 1 >= mGoodLvl) begin mInSvc = 1; mGood = 0; mBad = 0; end
      else mGood++;
    end
    check({tag, " parErr"}, parErr, sawBad);
    check({tag, " outOfService"}, outOfService, !mInSvc);
  endtask

  task automatic idleRow(input string tag);
    applyRow(1'b1, 2'b00, 2'b00, 16'h1357, 16'h2468, tag);
  endtask

  task automatic badRow(input string tag);
    applyRow(1'b1, 2'b01, 2'b01, 16'h0F0F, 16'h5550, tag);
  endtask

  initial begin
    @(negedge clk);
    doReset(3, 4);
    // table: R1 R2 R4 R6 R7 R10 R11 under thresholds 3 / 4
    for (int i = 0; i < NROWS; i++) begin
      applyRow(ROWS[i][36], ROWS[i][35:34], ROWS[i][33:32],
               ROWS[i][31:16], ROWS[i][15:0], "R1 R2 R4 R6 R7 R10 R11 table");
    end

    // R5: single error drops service at once
    doReset(1, 2);
    idleRow("R7 return after two clean");
    idleRow("R7 return after two clean");
    check("R7 back in service", outOfService, 1'b0);
    badRow("R5 single error");
    check("R5 out after one error", outOfService, 1'b1);

    // R8: zero thresholds act as one
    doReset(0, 0);
    idleRow("R8 zero good level");
    check("R8 in service after one clean", outOfService, 1'b0);
    badRow("R8 zero bad level");
    check("R8 out after one error", outOfService, 1'b1);

    // R9: threshold pins ignored after reset
    doReset(2, 1);
    badLevel = 8'd1;
    goodLevel = 8'd5;
    idleRow("R9 captured good level");
    check("R9 in service with captured level", outOfService, 1'b0);
    badRow("R9 first error");
    check("R9 stays in service", outOfService, 1'b0);
    badRow("R9 second error");
    check("R9 out at captured level", outOfService, 1'b1);

    // R2: multiple failures give one pulse that ends
    applyRow(1'b1, 2'b11, 2'b11, 16'h7000, 16'h6000, "R2 double failure");
    idleRow("R2 pulse ends");
    check("R2 low after clean", parErr, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule